// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block links two parallel data buses, A and B, through a selectable path. Each transfer direction has its own storage register, loaded when that direction's capture clock rises. A direction input chooses which bus is driven and which one is read. An active-low output enable turns both bus drivers off while both registers keep loading. For each direction, a select input chooses whether the driven bus gets the live word from the opposite bus or the word held in that direction's register. A word can therefore be parked in one register while a different word is passed live or taken from the other register.

The buses are split into separate input, output and output-enable ports, so there are no internal tristates. The pad ring or the bus fabric merges them. The capture clocks are sampled by the core clock `clk`. A capture clock that is low at one `clk` edge and high at the next is a rising edge, and the register loads the opposite bus at that second edge. All selection toward the outputs is combinational.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both storage registers to 0x00. A capture clock that is held high through reset and after it causes no load.
- R2: The A-to-B register loads `aIn` at the `clk` edge where `abClk` is high and was low at the previous edge. At every other edge it holds, including while `abClk` stays high.
- R3: The B-to-A register loads `bIn` at the `clk` edge where `baClk` is high and was low at the previous edge. At every other edge it holds.
- R4: While `outEnN` is 1, `aOe` and `bOe` are both 0 and `aOut` and `bOut` are both 0x00.
- R5: Both registers keep loading on their capture edges while `outEnN` is 1.
- R6: With `outEnN` at 0, `dirAtoB`=1 sets `bOe`=1 and `aOe`=0, and `dirAtoB`=0 sets `aOe`=1 and `bOe`=0. The two enables are never both 1.
- R7: While B is driven, `abSelStored`=0 gives `bOut`=`aIn` in the same cycle, and `abSelStored`=1 gives `bOut` equal to the A-to-B register.
- R8: While A is driven, `baSelStored`=0 gives `aOut`=`bIn` in the same cycle, and `baSelStored`=1 gives `aOut` equal to the B-to-A register.
- R9: When a capture edge arrives while the live path is selected, the live word still appears at the output, and the same word is loaded into the register.
- R10: A load in one direction never changes the register of the other direction.
- R11: With outputs enabled, the bus that is not driven has its output at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples the capture clocks |
| rst | input | 1 | Synchronous active-high reset |
| outEnN | input | 1 | Active-low enable for both bus drivers |
| dirAtoB | input | 1 | 1: B driven from A side; 0: A driven from B side |
| abClk | input | 1 | Capture clock of the A-to-B register |
| baClk | input | 1 | Capture clock of the B-to-A register |
| abSelStored | input | 1 | 1: B gets stored word; 0: B gets live A |
| baSelStored | input | 1 | 1: A gets stored word; 0: A gets live B |
| aIn | input | DATA_W | Word read from bus A |
| aOut | output | DATA_W | Word driven onto bus A |
| aOe | output | 1 | Drive enable for bus A |
| bIn | input | DATA_W | Word read from bus B |
| bOut | output | DATA_W | Word driven onto bus B |
| bOe | output | 1 | Drive enable for bus B |

## Verification
The assertions assume that every input changes away from the rising edge of `clk`, and that a capture clock rise is only judged once `rst` has been low for at least one edge. The load checks use the previous capture-clock level, and just after reset that level would otherwise disagree with the high level the control forces during reset. The bench drives every input at the falling edge of `clk` or between edges. It keeps each capture clock high for exactly one `clk` edge, except in the deliberate held-high case, and it releases reset before any capture it checks.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadAb;        // load A-to-B register this edge
    logic loadBa;        // load B-to-A register this edge
    logic driveA;        // bus A driven
    logic driveB;        // bus B driven
    logic pickStoredAb;  // B source: stored word
    logic pickStoredBa;  // A source: stored word
  } xcvr_strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         outEnN,
  input  logic         dirAtoB,
  input  logic         abClk,
  input  logic         baClk,
  input  logic         abSelStored,
  input  logic         baSelStored,
  output xcvr_strobe_t strb
);
  localparam int NDIR = 2;  // index 0: A-to-B, index 1: B-to-A

  logic [NDIR-1:0] capLvl;
  logic [NDIR-1:0] rise;

  assign capLvl = {baClk, abClk};

  // One edge detector per direction; reset level is high so a clock
  // held high across reset does not count as a rise.
  for (genvar d = 0; d < NDIR; d++) begin : g_edge
    logic prevLvl;
    always_ff @(posedge clk) begin
      if (rst) prevLvl <= 1'b1;
      else     prevLvl <= capLvl[d];
    end
    assign rise[d] = capLvl[d] & ~prevLvl;
  end

  always_comb begin
    strb.loadAb       = rise[0];
    strb.loadBa       = rise[1];
    strb.driveB       = ~outEnN & dirAtoB;
    strb.driveA       = ~outEnN & ~dirAtoB;
    strb.pickStoredAb = abSelStored;
    strb.pickStoredBa = baSelStored;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  xcvr_strobe_t      strb,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] bOut,
  output logic              aOe,
  output logic              bOe,
  output logic [DATA_W-1:0] storedAb,
  output logic [DATA_W-1:0] storedBa
);
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] regAb, regBa;
  logic [DATA_W-1:0] srcToB, srcToA;

  always_ff @(posedge clk) begin
    if (rst)              regAb <= ZERO;
    else if (strb.loadAb) regAb <= aIn;
  end

  always_ff @(posedge clk) begin
    if (rst)              regBa <= ZERO;
    else if (strb.loadBa) regBa <= bIn;
  end

  always_comb begin
    srcToB = strb.pickStoredAb ? regAb : aIn;
    srcToA = strb.pickStoredBa ? regBa : bIn;
    bOut   = strb.driveB ? srcToB : ZERO;
    aOut   = strb.driveA ? srcToA : ZERO;
    bOe    = strb.driveB;
    aOe    = strb.driveA;
  end

  assign storedAb = regAb;
  assign storedBa = regBa;
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              outEnN,
  input  logic              dirAtoB,
  input  logic              abClk,
  input  logic              baClk,
  input  logic              abSelStored,
  input  logic              baSelStored,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOe,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] bOut,
  output logic              bOe
);
  xcvr_strobe_t      strb;
  logic [DATA_W-1:0] storedAb, storedBa;

  xcvr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .outEnN(outEnN), .dirAtoB(dirAtoB),
    .abClk(abClk), .baClk(baClk),
    .abSelStored(abSelStored), .baSelStored(baSelStored),
    .strb(strb)
  );

  xcvr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut),
    .aOe(aOe), .bOe(bOe),
    .storedAb(storedAb), .storedBa(storedBa)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              outEnN,
  input logic              dirAtoB,
  input logic              abClk,
  input logic              baClk,
  input logic              abSelStored,
  input logic              baSelStored,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] bIn,
  input logic [DATA_W-1:0] aOut,
  input logic [DATA_W-1:0] bOut,
  input logic              aOe,
  input logic              bOe,
  input logic [DATA_W-1:0] storedAb,
  input logic [DATA_W-1:0] storedBa
);
  p_off_r4: assert property (@(posedge clk) disable iff (rst)
    outEnN |-> (!aOe && !bOe && aOut == '0 && bOut == '0));

  p_oe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(aOe && bOe));

  p_hold_ab_r2: assert property (@(posedge clk) disable iff (rst)
    !abClk |=> $stable(storedAb));

  p_load_ab_r2: assert property (@(posedge clk) disable iff (rst)
    (abClk && !$past(abClk) && !$past(rst)) |=> storedAb == $past(aIn));

  p_hold_ba_r3: assert property (@(posedge clk) disable iff (rst)
    !baClk |=> $stable(storedBa));

  p_load_ba_r3: assert property (@(posedge clk) disable iff (rst)
    (baClk && !$past(baClk) && !$past(rst)) |=> storedBa == $past(bIn));

  p_live_b_r7: assert property (@(posedge clk) disable iff (rst)
    (!outEnN && dirAtoB && !abSelStored) |-> (bOe && bOut == aIn));

  p_stored_b_r7: assert property (@(posedge clk) disable iff (rst)
    (!outEnN && dirAtoB && abSelStored) |-> (bOe && bOut == storedAb));

  p_live_a_r8: assert property (@(posedge clk) disable iff (rst)
    (!outEnN && !dirAtoB && !baSelStored) |-> (aOe && aOut == bIn));

  p_stored_a_r8: assert property (@(posedge clk) disable iff (rst)
    (!outEnN && !dirAtoB && baSelStored) |-> (aOe && aOut == storedBa));

  p_idle_bus_r11: assert property (@(posedge clk) disable iff (rst)
    (!outEnN && dirAtoB) |-> (!aOe && aOut == '0));
endmodule

bind dual_reg_xcvr xcvr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .outEnN(outEnN), .dirAtoB(dirAtoB),
  .abClk(abClk), .baClk(baClk),
  .abSelStored(abSelStored), .baSelStored(baSelStored),
  .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut),
  .aOe(aOe), .bOe(bOe),
  .storedAb(storedAb), .storedBa(storedBa)
);

// File: tb/tb_dual_reg_xcvr.sv
`timescale 1ns/1ps
module tb_dual_reg_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic outEnN = 1'b1, dirAtoB = 1'b0, abClk = 1'b0, baClk = 1'b0;
  logic abSelStored = 1'b0, baSelStored = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [W-1:0] mAb = '0, mBa = '0;  // bench model of the registers

  always #5 clk = ~clk;

  dual_reg_xcvr #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .outEnN(outEnN), .dirAtoB(dirAtoB),
    .abClk(abClk), .baClk(baClk),
    .abSelStored(abSelStored), .baSelStored(baSelStored),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read the stored words through the normal outputs (stored select, driven side)
  task automatic peekAb(output logic [W-1:0] v);
    outEnN = 1'b0; dirAtoB = 1'b1; abSelStored = 1'b1; #1; v = bOut;
  endtask
  task automatic peekBa(output logic [W-1:0] v);
    outEnN = 1'b0; dirAtoB = 1'b0; baSelStored = 1'b1; #1; v = aOut;
  endtask

  task automatic capAb(input logic [W-1:0] d);
    @(negedge clk); aIn = d; abClk = 1'b1;
    @(negedge clk); abClk = 1'b0; mAb = d;
  endtask
  task automatic capBa(input logic [W-1:0] d);
    @(negedge clk); bIn = d; baClk = 1'b1;
    @(negedge clk); baClk = 1'b0; mBa = d;
  endtask

  task automatic t_reset;  // R1
    logic [W-1:0] v;
    abClk = 1'b1; aIn = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    peekAb(v); chk("R1 AB clear, clock held high", v, 8'h00);
    peekBa(v); chk("R1 BA clear", v, 8'h00);
    @(negedge clk); abClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disabled;  // R4, R5
    logic [W-1:0] v;
    @(negedge clk); outEnN = 1'b1; aIn = 8'h11; bIn = 8'h22; #1;
    chk("R4 aOe off", {7'b0, aOe}, 8'h00);
    chk("R4 bOe off", {7'b0, bOe}, 8'h00);
    chk("R4 aOut zero", aOut, 8'h00);
    chk("R4 bOut zero", bOut, 8'h00);
    capAb(8'h5A); capBa(8'hA5);
    peekAb(v); chk("R5 AB loaded while disabled", v, 8'h5A);
    peekBa(v); chk("R5 BA loaded while disabled", v, 8'hA5);
    outEnN = 1'b1;
  endtask

  task automatic t_all_combos;  // R4 R6 R7 R8 R11 against model
    aIn = 8'h3C; bIn = 8'hC3;
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] eA, eB; logic eAoe, eBoe;
      {outEnN, dirAtoB, abSelStored, baSelStored} = i[3:0];
      #1;
      eBoe = !outEnN && dirAtoB;
      eAoe = !outEnN && !dirAtoB;
      eB = eBoe ? (abSelStored ? mAb : aIn) : 8'h00;
      eA = eAoe ? (baSelStored ? mBa : bIn) : 8'h00;
      chk("R6 aOe", {7'b0, aOe}, {7'b0, eAoe});
      chk("R6 bOe", {7'b0, bOe}, {7'b0, eBoe});
      chk("R7/R11 bOut", bOut, eB);
      chk("R8/R11 aOut", aOut, eA);
    end
  endtask

  task automatic t_live_follow;  // R7 R8 same-cycle selection
    outEnN = 1'b0; dirAtoB = 1'b1; abSelStored = 1'b0;
    aIn = 8'h81; #1; chk("R7 live follows A", bOut, 8'h81);
    aIn = 8'h7E; #1; chk("R7 live follows A again", bOut, 8'h7E);
    abSelStored = 1'b1; #1; chk("R7 select flip to stored", bOut, mAb);
    dirAtoB = 1'b0; baSelStored = 1'b0;
    bIn = 8'h99; #1; chk("R8 live follows B", aOut, 8'h99);
    baSelStored = 1'b1; #1; chk("R8 select flip to stored", aOut, mBa);
  endtask

  task automatic t_capture_live;  // R9
    logic [W-1:0] v;
    @(negedge clk);
    outEnN = 1'b0; dirAtoB = 1'b1; abSelStored = 1'b0;
    aIn = 8'hC7; abClk = 1'b1; #1;
    chk("R9 live during capture", bOut, 8'hC7);
    @(negedge clk); abClk = 1'b0; mAb = 8'hC7;
    chk("R9 live after capture", bOut, 8'hC7);
    aIn = 8'h00;
    peekAb(v); chk("R9 same word stored", v, 8'hC7);
  endtask

  task automatic t_held_high;  // R2 R3 no reload while clock stays high
    logic [W-1:0] v;
    @(negedge clk); aIn = 8'h42; abClk = 1'b1;
    @(negedge clk); aIn = 8'h24;
    @(negedge clk); aIn = 8'hEE;
    @(negedge clk); abClk = 1'b0; mAb = 8'h42;
    peekAb(v); chk("R2 only first rise loads", v, 8'h42);
    @(negedge clk); bIn = 8'h17; baClk = 1'b1;
    @(negedge clk); bIn = 8'h71;
    @(negedge clk); baClk = 1'b0; mBa = 8'h17;
    peekBa(v); chk("R3 only first rise loads", v, 8'h17);
  endtask

  task automatic t_isolation;  // R10
    logic [W-1:0] v;
    for (int k = 0; k < 4; k++) begin
      capAb(8'h10 + 8'(k));
      peekBa(v); chk("R10 BA untouched by AB load", v, mBa);
      capBa(8'hF0 - 8'(k));
      peekAb(v); chk("R10 AB untouched by BA load", v, mAb);
    end
    peekAb(v); chk("R2 last AB word", v, 8'h13);
    peekBa(v); chk("R3 last BA word", v, 8'hED);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_all_combos();
    t_live_follow();
    t_capture_live();
    t_held_high();
    t_isolation();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule